// File: doc/BRIEF.md
# General-Purpose I/O Port with Bit Set and Clear

This block is a memory-mapped general-purpose I/O port with up to 32 pins. Software reaches it through a simple register bus: a byte address, a write enable, write data, and read data that follows the address in the same cycle. Each pin has a direction bit and an output latch bit. Each pin is presented to the pad as three signals: an output enable, an output value, and a sampled input value.

Software can load the output latch as a whole word. It can also change single bits without a read-modify-write, using two separate addresses. At the first address, every 1 in the write data sets the matching latch bit. At the second, every 1 clears it. Pin levels pass through a multi-flop synchronizer before software can read them. The input register always shows the pin level, including for pins that drive, so a value written to the latch appears on the input read-back only after the synchronizer delay.

Top module: `gpio_port_sr`

## Requirements
- R1: After a synchronous active-low reset, every direction bit is 1 (input), the output latch is all zeros, and every output enable is low.
- R2: A write to offset 0x00 loads the direction register from the write data. A direction bit of 1 makes the pin an input, and 0 makes it a driven output. The pin's output enable is high exactly when its direction bit is 0.
- R3: A write to offset 0x04 replaces the whole output latch. The pin output values equal the latch from the cycle after the write.
- R4: A write to offset 0x08 sets each latch bit whose write-data bit is 1. Every other latch bit keeps its value.
- R5: A write to offset 0x0C clears each latch bit whose write-data bit is 1. Every other latch bit keeps its value.
- R6: A read of offset 0x10 returns the pin inputs as they were two rising edges earlier. This holds for input pins and for driven pins alike.
- R7: Reads of offsets 0x04, 0x08 and 0x0C return the current output latch. A read of 0x00 returns the direction register. Read-data bits above the pin count read as 0.
- R8: Writes to offset 0x10, or to any address outside the four writable offsets, change neither the direction register nor the latch. Reads of an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_data | input | BUS_W (32) | Write data |
| bus_rd_data | output | BUS_W (32) | Read data for bus_addr, combinational |
| pin_in | input | NUM_PINS (32) | Raw pin levels from the pads |
| pin_out | output | NUM_PINS (32) | Output latch driven toward the pads |
| pin_oe | output | NUM_PINS (32) | Per-pin output enable, high when driving |

## Verification
Two functions can act on the same pin in the same cycle:
- a bit-set or bit-clear write changes the output latch;
- the synchronizer samples that pin as it is looped back from its own driven value.

The bench ties each driven pin's output to its input and issues a set write to driven pins. It then reads the input register on each of the following edges. The read must keep the old level for exactly two edges after the latch update before it shows the new one, independent of the external level on those pins. The set and clear sweeps also compare every bit outside the write mask with the latch value from before the write.

// File: rtl/gpio_sr_pkg.sv
// Package: shared register offsets and decode for the GPIO port.
// Assumes byte addressing with word-aligned registers in a 32-byte window.
package gpio_sr_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_LAT  = 3'd1,
        SEL_SET  = 3'd2,
        SEL_CLR  = 3'd3,
        SEL_PIN  = 3'd4,
        SEL_NONE = 3'd7
    } gpio_sel_e;

    // Map a byte address onto the register it selects.
    function automatic gpio_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        gpio_sel_e s;
        case (a)
            5'h00:   s = SEL_DIR;
            5'h04:   s = SEL_LAT;
            5'h08:   s = SEL_SET;
            5'h0C:   s = SEL_CLR;
            5'h10:   s = SEL_PIN;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Carries raw pin levels through a chain of SYNC_STAGES flops per pin.
// Assumes pins are asynchronous to clk. The chain is cleared on reset.
module gpio_in_sync #(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] raw_in,
    output logic [NUM_PINS-1:0] sync_out
);

    logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= raw_in;
    end

    genvar k;
    generate
        for (k = 1; k < SYNC_STAGES; k++) begin : g_stage
            // Each later stage resamples its predecessor.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[k] <= '0;
                else        stage_q[k] <= stage_q[k-1];
            end

            AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> stage_q[k] == $past(stage_q[k-1])); // R6
        end
    endgenerate

    assign sync_out = stage_q[SYNC_STAGES-1];

    AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage_q[0] == $past(raw_in)); // R6

endmodule

// File: rtl/gpio_regbank.sv
// Module: gpio_regbank
// Holds the direction register and output latch. Applies whole-word, set
// and clear writes, and muxes read data from the address.
// Assumes one write per strobe cycle and NUM_PINS <= BUS_W.
module gpio_regbank
    import gpio_sr_pkg::*;
#(
    parameter int          NUM_PINS = 32,
    parameter int          BUS_W    = 32,
    parameter logic [31:0] DIR_RST  = 32'hFFFF_FFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [BUS_W-1:0]    wr_data,
    input  logic [NUM_PINS-1:0] pin_sync,
    output logic [BUS_W-1:0]    rd_data,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] lat_q
);

    localparam int PAD_W = BUS_W - NUM_PINS;

    gpio_sel_e           sel;
    logic [NUM_PINS-1:0] wmask;
    logic [NUM_PINS-1:0] lat_d;
    logic [NUM_PINS-1:0] rd_core;

    // Decode the addressed register.
    always_comb sel = decode_sel(addr);

    assign wmask = wr_data[NUM_PINS-1:0];

    // Direction register: whole-word load only.
    always_ff @(posedge clk) begin
        if (!rst_n)                        dir_q <= DIR_RST[NUM_PINS-1:0];
        else if (wr_en && sel == SEL_DIR)  dir_q <= wmask;
    end

    genvar b;
    generate
        for (b = 0; b < NUM_PINS; b++) begin : g_lat_bit
            // Per-bit next value for the three write styles.
            always_comb begin
                lat_d[b] = lat_q[b];
                if (wr_en) begin
                    case (sel)
                        SEL_LAT: lat_d[b] = wmask[b];
                        SEL_SET: if (wmask[b]) lat_d[b] = 1'b1;
                        SEL_CLR: if (wmask[b]) lat_d[b] = 1'b0;
                        default: lat_d[b] = lat_q[b];
                    endcase
                end
            end
        end
    endgenerate

    // Output latch register.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    // Read mux; set and clear addresses reflect the latch.
    always_comb begin
        case (sel)
            SEL_DIR:                   rd_core = dir_q;
            SEL_LAT, SEL_SET, SEL_CLR: rd_core = lat_q;
            SEL_PIN:                   rd_core = pin_sync;
            default:                   rd_core = '0;
        endcase
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, rd_core};
        end else begin : g_nopad
            assign rd_data = rd_core;
        end
    endgenerate

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 5'h00) |=> dir_q == $past(wmask)); // R2

    AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 5'h04) |=> lat_q == $past(wmask)); // R3

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 5'h08) |=>
        ((lat_q & $past(wmask)) == $past(wmask)) &&
        ((lat_q & ~$past(wmask)) == ($past(lat_q) & ~$past(wmask)))); // R4

    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 5'h0C) |=>
        ((lat_q & $past(wmask)) == '0) &&
        ((lat_q & ~$past(wmask)) == ($past(lat_q) & ~$past(wmask)))); // R5

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != 5'h00 && addr != 5'h04 && addr != 5'h08 && addr != 5'h0C)
        |=> $stable(dir_q) && $stable(lat_q)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dir_q) && $stable(lat_q)); // R8

endmodule

// File: rtl/gpio_port_sr.sv
// Module: gpio_port_sr (top)
// GPIO port: register bank plus input synchronizer, with tri-state style pins.
// Assumes the pad ring resolves pin_out and pin_oe. Pin muxing is external.
module gpio_port_sr
    import gpio_sr_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int BUS_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [BUS_W-1:0]    bus_wr_data,
    output logic [BUS_W-1:0]    bus_rd_data,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] lat_q;

    gpio_in_sync #(
        .NUM_PINS    (NUM_PINS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regbank #(
        .NUM_PINS (NUM_PINS),
        .BUS_W    (BUS_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr_en    (bus_wr_en),
        .wr_data  (bus_wr_data),
        .pin_sync (pin_sync),
        .rd_data  (bus_rd_data),
        .dir_q    (dir_q),
        .lat_q    (lat_q)
    );

    // Pads drive where the direction bit is 0.
    assign pin_oe  = ~dir_q;
    assign pin_out = lat_q;

    AST_OE_AFTER_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 5'h00) |=> pin_oe == ~$past(bus_wr_data[NUM_PINS-1:0])); // R2

    AST_OUT_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 5'h08) |=>
        ((pin_out & $past(bus_wr_data[NUM_PINS-1:0])) == $past(bus_wr_data[NUM_PINS-1:0]))); // R4

endmodule

// File: tb/test_gpio_port_sr.sv
module test_gpio_port_sr;

    localparam int NP = 8;
    localparam int BW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic          bus_wr_en = 1'b0;
    logic [BW-1:0] bus_wr_data = '0;
    logic [BW-1:0] bus_rd_data;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [NP-1:0] ext = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // Pad model: a driven pin reads back its own output level.
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    gpio_port_sr #(.NUM_PINS(NP), .BUS_W(BW), .SYNC_STAGES(2)) i_gpio_port_sr (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [BW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [BW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rd_data;
    endtask

    initial begin
        logic [BW-1:0] rv;
        logic [NP-1:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        bus_read(5'h00, rv); check("R1 dir", rv, 32'h0000_00FF);
        bus_read(5'h04, rv); check("R1 latch", rv, 32'h0);
        check("R1 oe", {24'h0, pin_oe}, 32'h0);

        // Direction sweep
        for (int d = 0; d < 256; d++) begin
            bus_write(5'h00, 32'hFFFF_FF00 | d);
            check("R2 oe", {24'h0, pin_oe}, {24'h0, ~d[7:0]});
            bus_read(5'h00, rv); check("R7 dir readback", rv, d);
        end

        // Whole-word latch sweep
        for (int v = 0; v < 256; v++) begin
            bus_write(5'h04, v);
            check("R3 pin_out", {24'h0, pin_out}, v);
            bus_read(5'h04, rv); check("R3 read", rv, v);
        end

        // Set and clear sweeps
        for (int s = 0; s < 256; s++) begin
            for (int m = 0; m < 256; m += 17) begin
                bus_write(5'h04, s);
                bus_write(5'h08, 32'hFFFF_FF00 | m);
                check("R4 set", {24'h0, pin_out}, (s | m) & 8'hFF);
                bus_read(5'h08, rv); check("R7 set addr read", rv, (s | m) & 8'hFF);
                bus_write(5'h04, s);
                bus_write(5'h0C, m);
                check("R5 clear", {24'h0, pin_out}, s & ~m & 8'hFF);
                bus_read(5'h0C, rv); check("R7 clr addr read", rv, s & ~m & 8'hFF);
            end
        end

        // Input mode latency sweep
        bus_write(5'h00, 32'hFF);
        prev = ext;
        repeat (3) @(negedge clk);
        for (int v = 0; v < 256; v++) begin
            logic [7:0] nv;
            nv = v[7:0] ^ 8'h3C;
            @(negedge clk);
            ext = nv; bus_addr = 5'h10;
            @(negedge clk); #1;
            check("R6 one edge", bus_rd_data, {24'h0, prev});
            @(negedge clk); #1;
            check("R6 two edges", bus_rd_data, {24'h0, nv});
            prev = nv;
        end

        // Output mode: set write and loopback sampling collide
        bus_write(5'h04, 32'h0);
        bus_write(5'h00, 32'h0);
        ext = 8'hFF;
        repeat (3) @(negedge clk);
        bus_read(5'h10, rv); check("R6 driven low", rv, 32'h0);
        @(negedge clk);
        bus_addr = 5'h08; bus_wr_data = 32'h5A; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = 5'h10; #1;
        check("R6 loopback edge1", bus_rd_data, 32'h0);
        @(negedge clk); #1;
        check("R6 loopback edge2", bus_rd_data, 32'h0);
        @(negedge clk); #1;
        check("R6 loopback edge3", bus_rd_data, 32'h5A);

        // Ignored writes and unmapped reads
        bus_write(5'h00, 32'h0F);
        bus_write(5'h04, 32'hA5);
        bus_write(5'h10, 32'hFF);
        bus_write(5'h14, 32'h00);
        bus_write(5'h1C, 32'hFF);
        bus_write(5'h02, 32'h00);
        bus_write(5'h09, 32'hFF);
        bus_read(5'h00, rv); check("R8 dir kept", rv, 32'h0F);
        bus_read(5'h04, rv); check("R8 latch kept", rv, 32'hA5);
        check("R8 oe kept", {24'h0, pin_oe}, 32'hF0);
        bus_read(5'h14, rv); check("R8 unmapped read", rv, 32'h0);
        bus_read(5'h02, rv); check("R8 unaligned read", rv, 32'h0);

        // Reset again mid-operation
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(5'h00, rv); check("R1 dir after reset", rv, 32'hFF);
        bus_read(5'h0C, rv); check("R1 latch after reset", rv, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule